// File: doc/BRIEF.md
# Memory Barrier Ordering Gate

The gate sits between an in-order issue stage and the memory pipeline. It holds back younger instructions after a barrier until the older work that the barrier depends on has drained. A barrier brings two masks. The 4-bit ordering mask pairs a class of older memory operation with a class of younger memory operation. The 3-bit completion mask asks for stronger forms of draining: an address lookaside, memory-issue completion, and full synchronisation.

The gate keeps three running counts of outstanding work: loads, stores and non-memory operations. Every issued store also places its address in a small in-order buffer, and that entry leaves the buffer when the store becomes globally visible. Each cycle the issue stage presents its next younger instruction, with the instruction's type and address. The gate raises `stall_o` if any active rule forbids that instruction from issuing. Completions reported in a cycle count towards that same cycle's decision. The active barrier retires on the first cycle in which everything it asked for is met.

Top module: `mem_order_gate`

## Requirements
- R1: After reset no barrier is active, all counts are zero, the store buffer is empty and `stall_o` is low.
- R2: Ordering bit 0 (load after load) stalls a younger load (`req_type_i`=2'b01) while any older load is outstanding.
- R3: Ordering bit 1 (load after store) stalls a younger load while any store is still pending.
- R4: Ordering bit 2 (store after load) stalls a younger store (`req_type_i`=2'b10) while any load is outstanding.
- R5: Ordering bit 3 (store after store) stalls a younger store while any store is still pending.
- R6: Completion bit 0 (lookaside) stalls a younger load only when its address equals, on every bit, the address of a pending store. It never stalls stores or other instructions.
- R7: Completion bit 1 (memory issue) stalls younger loads and stores while any load or store is outstanding. It does not stall other instructions (`req_type_i`=2'b00).
- R8: Completion bit 2 (sync) stalls every younger instruction, including non-memory ones, while any load, store or non-memory operation is outstanding.
- R9: With several bits set, a younger instruction stalls if any single active rule requires it. A barrier with both masks zero never causes a stall.
- R10: The active barrier retires on the first cycle in which all of its selected rules are met. A barrier that arrives in that cycle replaces it. A barrier that arrives while an earlier one is still unmet merges its masks into the active set.
- R11: A decrement strobe, or a store dequeue, in cycle N counts towards the stall decision of cycle N.
- R12: The store buffer holds 8 addresses. A younger store stalls while the buffer is full, unless a store dequeues in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bar_valid_i | input | 1 | Barrier issued this cycle |
| bar_omask_i | input | 4 | Ordering mask of the barrier |
| bar_cmask_i | input | 3 | Completion mask of the barrier |
| ld_inc_i | input | 1 | A load was issued |
| ld_dec_i | input | 1 | An outstanding load was performed |
| st_inc_i | input | 1 | A store was issued; its address is pushed |
| st_addr_i | input | AW | Address of the issued store |
| st_dec_i | input | 1 | The oldest pending store became globally visible |
| op_inc_i | input | 1 | A non-memory operation was issued |
| op_dec_i | input | 1 | A non-memory operation completed |
| req_valid_i | input | 1 | A younger instruction is requesting issue |
| req_type_i | input | 2 | 00 other, 01 load, 10 store |
| req_addr_i | input | AW | Address of the requesting instruction |
| stall_o | output | 1 | Requesting instruction must wait |

## Verification
The retirement of a barrier and the arrival of the next barrier can fall in the same cycle. So can a completion strobe and a younger request that the completion releases. Directed sequences force both cases. One sequence issues a store-after-store barrier in exactly the cycle where the last older load finishes a load-after-load barrier. Another drops a count to zero in the cycle a stalled request is presented. Random stimulus also raises barriers, strobes and requests together in the same cycle, and a bench reference model judges each cycle's stall from the requirement rules.

// File: rtl/mog_pkg.sv
package mog_pkg;
  typedef enum logic [1:0] {
    OP_OTHER = 2'b00,
    OP_LOAD  = 2'b01,
    OP_STORE = 2'b10
  } op_e;

  localparam int OM_LDLD = 0;
  localparam int OM_STLD = 1;
  localparam int OM_LDST = 2;
  localparam int OM_STST = 3;
  localparam int CM_LOOK = 0;
  localparam int CM_MISS = 1;
  localparam int CM_SYNC = 2;
endpackage

// File: rtl/mog_counter.sv
module mog_counter #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          clear_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i) cnt_q <= cnt_q + 1'b1;
    else if (!inc_i && dec_i) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o   = cnt_q;
  // same-cycle decrement counts
  assign clear_o = (cnt_q == '0) || ((cnt_q == CW'(1)) && dec_i);

  // R11
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (cnt_q != '0));
endmodule

// File: rtl/mog_store_buf.sv
module mog_store_buf #(
  parameter int DEPTH = 8,
  parameter int AW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          pop_i,
  input  logic [AW-1:0] probe_addr_i,
  output logic          full_o,
  output logic          clear_o,
  output logic          hit_o
);
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [AW-1:0]   mem_q [DEPTH];
  logic [IW-1:0]   head_q, tail_q;
  logic [CNTW-1:0] cnt_q;
  logic [DEPTH-1:0] hit_v;

  function automatic logic [IW-1:0] ptr_nxt(logic [IW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[tail_q] <= push_addr_i;
        tail_q        <= ptr_nxt(tail_q);
      end
      if (pop_i) head_q <= ptr_nxt(head_q);
      if (push_i && !pop_i) cnt_q <= cnt_q + 1'b1;
      else if (!push_i && pop_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    int   off;
    logic vld;
    always_comb begin
      off = (g >= int'(head_q)) ? g - int'(head_q) : g + DEPTH - int'(head_q);
      // entry leaving this cycle no longer blocks
      vld = (off < int'(cnt_q)) && !(pop_i && off == 0);
    end
    assign hit_v[g] = vld && (mem_q[g] == probe_addr_i);
  end

  assign full_o  = (int'(cnt_q) == DEPTH);
  assign clear_o = (cnt_q == '0) || ((cnt_q == CNTW'(1)) && pop_i);
  assign hit_o   = |hit_v;

  // R12
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> !full_o);
  // R12
  no_pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/mem_order_gate.sv
module mem_order_gate
  import mog_pkg::*;
#(
  parameter int AW       = 32,
  parameter int SB_DEPTH = 8,
  parameter int CW       = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bar_valid_i,
  input  logic [3:0]    bar_omask_i,
  input  logic [2:0]    bar_cmask_i,
  input  logic          ld_inc_i,
  input  logic          ld_dec_i,
  input  logic          st_inc_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic          st_dec_i,
  input  logic          op_inc_i,
  input  logic          op_dec_i,
  input  logic          req_valid_i,
  input  logic [1:0]    req_type_i,
  input  logic [AW-1:0] req_addr_i,
  output logic          stall_o
);
  logic [3:0]    om_q;
  logic [2:0]    cm_q;
  logic [CW-1:0] ld_cnt, op_cnt;
  logic          ld_clr, op_clr, st_clr, mem_clr, all_clr;
  logic          sb_full, sb_hit;
  logic          active, done;
  logic          hold_ld, hold_st, hold_ot, hold_full;
  op_e           rtype;

  mog_counter #(.CW(CW)) u_ld_cnt (
    .clk_i, .rst_ni, .inc_i(ld_inc_i), .dec_i(ld_dec_i),
    .cnt_o(ld_cnt), .clear_o(ld_clr)
  );

  mog_counter #(.CW(CW)) u_op_cnt (
    .clk_i, .rst_ni, .inc_i(op_inc_i), .dec_i(op_dec_i),
    .cnt_o(op_cnt), .clear_o(op_clr)
  );

  mog_store_buf #(.DEPTH(SB_DEPTH), .AW(AW)) u_sbuf (
    .clk_i, .rst_ni,
    .push_i(st_inc_i), .push_addr_i(st_addr_i),
    .pop_i(st_dec_i), .probe_addr_i(req_addr_i),
    .full_o(sb_full), .clear_o(st_clr), .hit_o(sb_hit)
  );

  assign mem_clr = ld_clr & st_clr;
  assign all_clr = mem_clr & op_clr;
  assign active  = (om_q != '0) || (cm_q != '0);
  assign rtype   = op_e'(req_type_i);

  // every selected rule met
  assign done = !(((om_q[OM_LDLD] | om_q[OM_LDST]) & !ld_clr) |
                  ((om_q[OM_STLD] | om_q[OM_STST] | cm_q[CM_LOOK]) & !st_clr) |
                  (cm_q[CM_MISS] & !mem_clr) |
                  (cm_q[CM_SYNC] & !all_clr));

  assign hold_ot = cm_q[CM_SYNC] & !all_clr;
  assign hold_ld = (om_q[OM_LDLD] & !ld_clr) | (om_q[OM_STLD] & !st_clr) |
                   (cm_q[CM_LOOK] & sb_hit) | (cm_q[CM_MISS] & !mem_clr) | hold_ot;
  assign hold_st = (om_q[OM_LDST] & !ld_clr) | (om_q[OM_STST] & !st_clr) |
                   (cm_q[CM_MISS] & !mem_clr) | hold_ot;
  assign hold_full = sb_full & !st_dec_i;

  always_comb begin
    stall_o = 1'b0;
    if (req_valid_i) begin
      unique case (rtype)
        OP_LOAD:  stall_o = hold_ld;
        OP_STORE: stall_o = hold_st | hold_full;
        default:  stall_o = hold_ot;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      om_q <= '0;
      cm_q <= '0;
    end else if (bar_valid_i) begin
      om_q <= (done ? 4'b0 : om_q) | bar_omask_i;
      cm_q <= (done ? 3'b0 : cm_q) | bar_cmask_i;
    end else if (done) begin
      om_q <= '0;
      cm_q <= '0;
    end
  end

  // R9
  zero_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bar_valid_i && bar_omask_i == '0 && bar_cmask_i == '0 && !active) |=> !active);
  // R10
  retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && done && !bar_valid_i) |=> !active);
  // R8
  other_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && rtype == OP_OTHER && stall_o) |-> (cm_q[CM_SYNC] && !all_clr));
  // R6
  lookaside_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && rtype == OP_LOAD && stall_o && om_q == '0 && cm_q == 3'b001) |-> sb_hit);
  // R1
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !active) |-> (rtype == OP_STORE && sb_full));
endmodule

// File: tb/mem_order_gate_test.sv
module mem_order_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SBD = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic b_bar, b_li, b_ld, b_si, b_sd, b_oi, b_od, b_rv;
  logic [3:0] b_om;
  logic [2:0] b_cm;
  logic [1:0] b_rt;
  logic [AW-1:0] b_sa, b_ra;
  logic stall;

  int tests = 0, fails = 0;
  int ml = 0, mo = 0;
  logic [AW-1:0] sq[$];
  logic [3:0] mom = '0;
  logic [2:0] mcm = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_order_gate #(.AW(AW), .SB_DEPTH(SBD), .CW(5)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .bar_valid_i(b_bar), .bar_omask_i(b_om), .bar_cmask_i(b_cm),
    .ld_inc_i(b_li), .ld_dec_i(b_ld),
    .st_inc_i(b_si), .st_addr_i(b_sa), .st_dec_i(b_sd),
    .op_inc_i(b_oi), .op_dec_i(b_od),
    .req_valid_i(b_rv), .req_type_i(b_rt), .req_addr_i(b_ra),
    .stall_o(stall)
  );

  function automatic logic lclr(); return (ml - int'(b_ld)) == 0; endfunction
  function automatic logic sclr(); return (sq.size() - int'(b_sd)) == 0; endfunction
  function automatic logic oclr(); return (mo - int'(b_od)) == 0; endfunction

  function automatic logic hit();
    for (int i = (b_sd ? 1 : 0); i < sq.size(); i++)
      if (sq[i] == b_ra) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic done_m();
    return !(((mom[0] | mom[2]) & !lclr()) | ((mom[1] | mom[3] | mcm[0]) & !sclr()) |
             (mcm[1] & !(lclr() & sclr())) | (mcm[2] & !(lclr() & sclr() & oclr())));
  endfunction

  function automatic logic exp_stall();
    logic sy, ms;
    sy = mcm[2] & !(lclr() & sclr() & oclr());
    ms = mcm[1] & !(lclr() & sclr());
    if (!b_rv) return 1'b0;
    case (b_rt)
      2'b01: return (mom[0] & !lclr()) | (mom[1] & !sclr()) | (mcm[0] & hit()) | ms | sy;
      2'b10: return (mom[2] & !lclr()) | (mom[3] & !sclr()) | ms | sy |
                    (sq.size() == SBD && !b_sd);
      default: return sy;
    endcase
  endfunction

  task automatic clr();
    b_bar = 0; b_om = 0; b_cm = 0; b_li = 0; b_ld = 0; b_si = 0; b_sd = 0;
    b_oi = 0; b_od = 0; b_rv = 0; b_rt = 0; b_sa = 0; b_ra = 0;
  endtask

  // inputs set by caller after a negedge; check, advance model, wait next negedge
  task automatic tick(string tag);
    logic e, d;
    #1;
    e = exp_stall();
    tests++;
    if (stall !== e) begin
      fails++;
      $display("FAIL %s: stall_o actual %b expected %b", tag, stall, e);
    end
    d = done_m();
    if (b_bar) begin
      mom = (d ? 4'b0 : mom) | b_om;
      mcm = (d ? 3'b0 : mcm) | b_cm;
    end else if (d) begin
      mom = 0; mcm = 0;
    end
    ml = ml + int'(b_li) - int'(b_ld);
    mo = mo + int'(b_oi) - int'(b_od);
    if (b_sd) void'(sq.pop_front());
    if (b_si) sq.push_back(b_sa);
    @(negedge clk);
    clr();
  endtask

  task automatic req(logic [1:0] t, logic [AW-1:0] a);
    b_rv = 1; b_rt = t; b_ra = a;
  endtask

  task automatic bar(logic [3:0] o, logic [2:0] c);
    b_bar = 1; b_om = o; b_cm = c;
  endtask

  function automatic logic [AW-1:0] pick_addr(int unsigned r);
    case (r % 4)
      0: return 32'h0000_0100;
      1: return 32'h8000_0100;
      2: return 32'h0000_0104;
      default: return 32'h0000_0200;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    clr();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    req(2'b01, 0); tick("R1");
    req(2'b10, 0); tick("R1");
    req(2'b00, 0); tick("R1");

    // R2 load after load, R11 same-cycle release
    b_li = 1; tick("R2");
    bar(4'b0001, 0); tick("R2");
    req(2'b01, 0); tick("R2");
    req(2'b10, 0); tick("R2");
    b_ld = 1; req(2'b01, 0); tick("R11");
    tick("R2");

    // R3 load after store
    b_si = 1; b_sa = 32'h10; tick("R3");
    bar(4'b0010, 0); tick("R3");
    req(2'b01, 32'h20); tick("R3");
    b_sd = 1; req(2'b01, 32'h20); tick("R11");
    tick("R3");

    // R4 store after load
    b_li = 1; tick("R4");
    bar(4'b0100, 0); tick("R4");
    req(2'b10, 0); tick("R4");
    req(2'b01, 0); tick("R4");
    b_ld = 1; tick("R4");
    tick("R4");

    // R5 store after store
    b_si = 1; b_sa = 32'h30; tick("R5");
    bar(4'b1000, 0); tick("R5");
    req(2'b10, 0); tick("R5");
    b_sd = 1; req(2'b10, 0); tick("R5");
    tick("R5");

    // R6 lookaside, full-width compare
    b_si = 1; b_sa = 32'h0000_0100; tick("R6");
    bar(0, 3'b001); tick("R6");
    req(2'b01, 32'h0000_0100); tick("R6");
    req(2'b01, 32'h8000_0100); tick("R6");
    req(2'b10, 32'h0000_0100); tick("R6");
    b_sd = 1; req(2'b01, 32'h0000_0100); tick("R6");
    tick("R6");

    // R7 memory issue
    b_li = 1; tick("R7");
    bar(0, 3'b010); tick("R7");
    req(2'b10, 0); tick("R7");
    req(2'b00, 0); tick("R7");
    b_ld = 1; tick("R7");
    tick("R7");

    // R8 sync covers non-memory
    b_oi = 1; tick("R8");
    bar(0, 3'b100); tick("R8");
    req(2'b00, 0); tick("R8");
    b_od = 1; req(2'b00, 0); tick("R8");
    tick("R8");

    // R9 zero masks, then combined rules
    b_li = 1; tick("R9");
    bar(0, 0); tick("R9");
    req(2'b01, 0); tick("R9");
    b_si = 1; b_sa = 32'h44; tick("R9");
    bar(4'b1001, 0); tick("R9");
    b_ld = 1; req(2'b10, 0); tick("R9");
    req(2'b10, 0); tick("R9");
    b_sd = 1; tick("R9");
    tick("R9");

    // R10 retire and new barrier in same cycle; merge while unmet
    b_li = 1; b_si = 1; b_sa = 32'h50; tick("R10");
    bar(4'b0001, 0); tick("R10");
    b_ld = 1; bar(4'b1000, 0); tick("R10");
    req(2'b10, 0); tick("R10");
    req(2'b01, 0); tick("R10");
    b_li = 1; tick("R10");
    bar(0, 3'b100); tick("R10");
    req(2'b01, 0); tick("R10");
    b_sd = 1; tick("R10");
    req(2'b01, 0); tick("R10");
    b_ld = 1; tick("R10");
    req(2'b00, 0); tick("R10");

    // R12 full store buffer
    for (int i = 0; i < SBD; i++) begin
      b_si = 1; b_sa = 32'h1000 + AW'(i); tick("R12");
    end
    req(2'b10, 0); tick("R12");
    req(2'b01, 0); tick("R12");
    b_sd = 1; req(2'b10, 0); tick("R12");
    for (int i = 0; i < SBD - 1; i++) begin
      b_sd = 1; tick("R12");
    end

    // random mix
    for (int n = 0; n < 4000; n++) begin
      b_li = (ml < 20) && ($urandom % 3 == 0);
      b_ld = (ml > 0) && ($urandom % 3 == 0);
      b_oi = (mo < 20) && ($urandom % 4 == 0);
      b_od = (mo > 0) && ($urandom % 3 == 0);
      b_sd = (sq.size() > 0) && ($urandom % 3 == 0);
      b_si = (sq.size() < SBD || b_sd) && ($urandom % 3 == 0);
      b_sa = pick_addr($urandom);
      if ($urandom % 8 == 0) begin
        b_bar = 1; b_om = 4'($urandom); b_cm = 3'($urandom);
      end
      b_rv = ($urandom % 4 != 0);
      b_rt = 2'($urandom % 3);
      b_ra = pick_addr($urandom);
      tick("R9");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule